// File: doc/BRIEF.md
# Self-Timed Asynchronous Serial Transceiver

This block receives and sends asynchronous serial characters without being told the line rate. At start-up it waits for a first character whose least significant data bit is one. It counts system clocks while that character's start bit is low and keeps the count as the bit period. From then on the receiver samples every bit in the middle of its bit time, using the falling edge of each start bit as its timing reference. The transmitter sends bytes at the same measured period.

Each frame has one low start bit, eight data bits sent least significant bit first, and then one high stop bit. A mode input adds a second stop bit for slow teleprinter-style links. Received bytes leave on a valid/ready byte port. Bytes to send arrive on a second valid/ready port. The counter width sets the slowest rate that can be measured. The default of 21 bits holds a 110 baud bit at a 200 MHz clock, and the fastest rate is limited only by needing at least a few clocks per bit.

Top module: `autobaud_uart`

## Requirements
- R1: After reset, `txd` is 1, and `rx_valid`, `tx_ready` and `frame_err` are 0.
- R2: The bit period is the number of clocks that the synchronised line stays low during the first start bit after reset. That first character (bit 0 = 1) is also received and delivered. The period then stays fixed.
- R3: Until a period has been measured, `tx_ready` is 0 and `txd` stays at 1.
- R4: After lock, each frame is timed from its own start-bit falling edge, with bits sampled at half a period plus whole periods. The first data bit received becomes bit 0 of `rx_data`.
- R5: If the line is high again at the middle of a start bit, nothing is delivered and `frame_err` stays 0.
- R6: If the line is low at the middle of the stop bit, the byte is dropped (no `rx_valid`), and `frame_err` is 1 for exactly one cycle.
- R7: A byte accepted on the transmit port (`tx_valid` and `tx_ready` both 1 at a clock edge) is sent as: start bit 0, then eight data bits LSB first, then stop bit(s) of 1. Each bit lasts one period and starts at the accepting edge.
- R8: The number of stop bits is set by `two_stop`, sampled when the byte is accepted: 0 gives one stop bit, 1 gives two. `tx_ready` returns to 1 exactly 10 or 11 periods after the accepting edge.
- R9: If the line stays low for 2^CNT_W-1 clocks or more during measurement, detection is abandoned and the block stays unlocked. The next valid first character then locks it.
- R10: `rx_valid` stays 1 with the byte on `rx_data` until `rx_ready` is seen, and then falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_stop | input | 1 | 1 = transmit two stop bits |
| rxd | input | 1 | Serial input line (idle high) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes received byte |
| frame_err | output | 1 | One-cycle pulse: stop bit sampled low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte to send is offered |
| tx_ready | output | 1 | Transmitter locked and idle |
| txd | output | 1 | Serial output line (idle high) |

## Verification
The receive line passes through a two-flop synchroniser, so every receive result comes two clocks after the bench edge that caused it. The mid-stop sample sits half a period before the end of the stop bit. The bench therefore reads each received byte or error count once it has finished driving the stop bit. Transmit bits are read at the falling edge half a period into each bit, counted from the accepting edge. `tx_ready` is read half a clock before and half a clock after the edge that lies 10 or 11 periods later. The bench uses an 8-bit counter, so the overflow abort can be reached in a few hundred clocks.

// File: rtl/autobaud_uart.sv
module autobaud_uart #(
  parameter int CNT_W = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       two_stop,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       frame_err,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {RX_IDLE, RX_MEAS, RX_START, RX_DATA, RX_STOP} rx_st_t;

  function automatic logic [CNT_W-1:0] half_m1(input logic [CNT_W-1:0] p);
    logic [CNT_W-1:0] h;
    h = p >> 1;
    return (h == '0) ? '0 : h - 1'b1;
  endfunction

  logic [1:0]       rx_sync;
  logic             rx_s, rx_prev, fall;
  logic             locked;
  logic [CNT_W-1:0] period, rx_cnt;
  logic [CNT_W-1:0] per_m1;
  rx_st_t           rx_st;
  logic [2:0]       rx_bit;
  logic [7:0]       rx_sh;

  assign rx_s   = rx_sync[1];
  assign fall   = rx_prev & ~rx_s;
  assign per_m1 = period - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync   <= 2'b11;
      rx_prev   <= 1'b1;
      locked    <= 1'b0;
      period    <= '0;
      rx_cnt    <= '0;
      rx_st     <= RX_IDLE;
      rx_bit    <= '0;
      rx_sh     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_sync   <= {rx_sync[0], rxd};
      rx_prev   <= rx_s;
      frame_err <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (rx_st)
        RX_IDLE: if (fall) begin
          if (locked) begin
            rx_cnt <= half_m1(period);
            rx_st  <= RX_START;
          end else begin
            rx_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
            rx_st  <= RX_MEAS;
          end
        end
        RX_MEAS: begin
          if (rx_s) begin
            period <= rx_cnt;
            locked <= 1'b1;
            rx_cnt <= half_m1(rx_cnt);
            rx_bit <= '0;
            rx_st  <= RX_DATA;
          end else if (rx_cnt == CNT_MAX) begin
            rx_st <= RX_IDLE;
          end else begin
            rx_cnt <= rx_cnt + 1'b1;
          end
        end
        RX_START: begin
          if (rx_cnt != '0) rx_cnt <= rx_cnt - 1'b1;
          else if (rx_s) rx_st <= RX_IDLE;
          else begin
            rx_cnt <= per_m1;
            rx_bit <= '0;
            rx_st  <= RX_DATA;
          end
        end
        RX_DATA: begin
          if (rx_cnt != '0) rx_cnt <= rx_cnt - 1'b1;
          else begin
            rx_sh  <= {rx_s, rx_sh[7:1]};
            rx_cnt <= per_m1;
            rx_bit <= rx_bit + 1'b1;
            if (rx_bit == 3'd7) rx_st <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (rx_cnt != '0) rx_cnt <= rx_cnt - 1'b1;
          else begin
            if (rx_s) begin
              rx_data  <= rx_sh;
              rx_valid <= 1'b1;
            end else begin
              frame_err <= 1'b1;
            end
            rx_st <= RX_IDLE;
          end
        end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  logic             tx_busy;
  logic [10:0]      tx_sh;
  logic [3:0]       tx_bits;
  logic [CNT_W-1:0] tx_cnt;

  assign tx_ready = locked & ~tx_busy;
  assign txd      = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_bits <= '0;
      tx_cnt  <= '0;
    end else if (!tx_busy) begin
      if (tx_valid && tx_ready) begin
        tx_busy <= 1'b1;
        tx_sh   <= {2'b11, tx_data, 1'b0};
        tx_bits <= two_stop ? 4'd10 : 4'd9;
        tx_cnt  <= per_m1;
      end
    end else if (tx_cnt != '0) begin
      tx_cnt <= tx_cnt - 1'b1;
    end else if (tx_bits == '0) begin
      tx_busy <= 1'b0;
    end else begin
      tx_sh   <= {1'b1, tx_sh[10:1]};
      tx_bits <= tx_bits - 1'b1;
      tx_cnt  <= per_m1;
    end
  end
endmodule

// File: rtl/autobaud_uart_chk.sv
module autobaud_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       frame_err,
  input logic       locked,
  input logic       tx_busy
);
  a_r3_idle_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (txd && !tx_ready));

  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  a_r6_err_drops_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !$rose(rx_valid));

  a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
endmodule

bind autobaud_uart autobaud_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .frame_err(frame_err),
  .locked(locked), .tx_busy(tx_busy)
);

// File: tb/autobaud_uart_bench.sv
`timescale 1ns/1ps
module autobaud_uart_bench;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_stop = 1'b0;
  logic rxd = 1'b1;
  logic rx_ready = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, frame_err, tx_ready, txd;

  int checks = 0;
  int errors = 0;
  int got_n = 0;
  int err_n = 0;
  logic [7:0] got_byte = '0;

  always #2.5 clk = ~clk;

  autobaud_uart #(.CNT_W(8)) u_autobaud_uart (
    .clk(clk), .rst_n(rst_n), .two_stop(two_stop), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .frame_err(frame_err), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      got_byte = rx_data;
      got_n++;
    end
    if (rst_n && frame_err) err_n++;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (P) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stop_v);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stop_v);
    rxd = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic tx_frame(input logic [7:0] b, input logic two);
    int nb;
    logic [10:0] exp_f;
    nb = two ? 11 : 10;
    exp_f = {2'b11, b, 1'b0};
    while (!tx_ready) @(negedge clk);
    two_stop = two;
    tx_data = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    two_stop = ~two;
    for (int k = 0; k < nb; k++) begin
      repeat (P/2) @(negedge clk);
      chk(k == 0 ? "R7 start" : (k > 8 ? "R8 stop" : "R7 data"), txd, exp_f[k]);
      repeat (P - P/2) @(negedge clk);
    end
    chk("R8 ready timing", tx_ready, 1'b1);
  endtask

  task automatic tx_ready_edge(input logic two);
    int nb;
    nb = two ? 11 : 10;
    while (!tx_ready) @(negedge clk);
    two_stop = two;
    tx_data = 8'h81;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (nb * P - 1) @(negedge clk);
    chk("R8 busy before end", tx_ready, 1'b0);
    @(negedge clk);
    chk("R8 ready at end", tx_ready, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0, e0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", txd, 1'b1);
    chk("R1 rx_valid", rx_valid, 1'b0);
    chk("R1 tx_ready", tx_ready, 1'b0);
    chk("R1 frame_err", frame_err, 1'b0);

    tx_valid = 1'b1;
    tx_data = 8'h00;
    repeat (20) @(negedge clk);
    chk("R3 no accept", tx_ready, 1'b0);
    chk("R3 txd idle", txd, 1'b1);
    tx_valid = 1'b0;

    rxd = 1'b0;
    repeat (300) @(negedge clk);
    rxd = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 overflow unlocked", tx_ready, 1'b0);
    chk("R9 nothing received", got_n, 0);

    rx_frame(8'h55, 1'b1);
    chk("R2 first byte count", got_n, 1);
    chk("R2 first byte", got_byte, 8'h55);
    chk("R2 locked", tx_ready, 1'b1);

    for (int b = 0; b < 256; b++) begin
      n0 = got_n;
      rx_frame(b[7:0], 1'b1);
      chk("R4 count", got_n, n0 + 1);
      chk("R4 byte", got_byte, b[7:0]);
    end

    n0 = got_n; e0 = err_n;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * P) @(negedge clk);
    chk("R5 glitch no byte", got_n, n0);
    chk("R5 glitch no err", err_n, e0);
    rx_frame(8'hC3, 1'b1);
    chk("R5 after glitch", got_byte, 8'hC3);

    n0 = got_n; e0 = err_n;
    rx_frame(8'hA5, 1'b0);
    repeat (P) @(negedge clk);
    chk("R6 err pulse", err_n, e0 + 1);
    chk("R6 dropped", got_n, n0);
    chk("R6 no valid", rx_valid, 1'b0);

    rx_ready = 1'b0;
    rx_frame(8'h3C, 1'b1);
    repeat (3 * P) @(negedge clk);
    chk("R10 held valid", rx_valid, 1'b1);
    chk("R10 held data", rx_data, 8'h3C);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
    chk("R10 taken", rx_valid, 1'b0);
    chk("R10 byte seen", got_byte, 8'h3C);
    rx_ready = 1'b1;

    for (int b = 0; b < 256; b++) tx_frame(b[7:0], 1'b0);
    tx_frame(8'h96, 1'b1);
    tx_frame(8'h01, 1'b1);
    tx_ready_edge(1'b0);
    tx_ready_edge(1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule